// File: doc/BRIEF.md
# Extended SMRAM Control and Remap

This block holds the 8-bit control byte for extended system-management memory and decodes CPU addresses with it. Two windows are decoded. The high SMRAM window is a fixed 128 KB range at 0xFEDA0000–0xFEDBFFFF, which is folded down onto the legacy DRAM range 0xA0000–0xBFFFF. The TSEG window is a 1 MB block at a base address set by a parameter. A window only responds when its own control bit and the global SMRAM enable input are both 1.

Each address is decoded combinationally. The block reports a hit for each window and drives the DRAM address. A valid CPU access that lands in either enabled window while the CPU is outside SMM sets a sticky violation flag. Software clears that flag by writing 1 to its bit.

A lock input seals the two window-enable bits. A two-state controller sets the seal:

- **OPEN** is the state after reset.
- The transition **OPEN→SEALED** is taken on any cycle where the lock input is high.
- **SEALED** holds until reset.

While the lock input is high, or while the controller is in SEALED, writes cannot change the window-enable bits.

Top module: `xsmm_ctrl`

## Requirements
- R1: After reset, a read at the register offset (0x61) returns 0x38. A read at any other offset returns 0x00.
- R2: Bit 7 is the high-window enable. When bit 7 and `smram_glb_en` are both 1, an address in 0xFEDA0000–0xFEDBFFFF raises `hi_smram_hit`, and `dram_addr` equals the address minus 0xFED00000. In every other case `hi_smram_hit` is 0.
- R3: Bits 5, 4 and 3 always read as 1, whatever value is written.
- R4: Bits 2 and 1 always read as 0, whatever value is written.
- R5: Bit 6 is the violation flag.
  - It reads 1 from the cycle after any qualifying access.
  - A qualifying access has `cpu_valid`=1 and `cpu_in_smm`=0, and hits either window.
  - The flag is cleared only by a write with bit 6 = 1. Writing 0 to bit 6 leaves the flag unchanged.
  - If a set and a clear happen in the same cycle, the set wins.
- R6: Bit 0 is the TSEG enable. When bit 0 and `smram_glb_en` are both 1, an address in [TSEG_BASE, TSEG_BASE + 1 MB) raises `tseg_hit`, and `dram_addr` equals the address unchanged.
- R7: A write cannot change bits 7 and 0 in either of these cases:
  - `cfg_lock` is high in that cycle.
  - `cfg_lock` has been seen high at any point since reset.

  The violation-flag clear still works while locked.
- R8: Writes at offsets other than 0x61 have no effect. An address outside both enabled windows gives no hit and passes to `dram_addr` unchanged.
- R9: An access with `cpu_in_smm`=1, or with `cpu_valid`=0, never sets the violation flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | REG_AW | Register port offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| cpu_valid | input | 1 | A CPU access is present this cycle |
| cpu_addr | input | ADDR_W | CPU physical address |
| cpu_in_smm | input | 1 | CPU is executing in SMM |
| smram_glb_en | input | 1 | Global SMRAM enable |
| cfg_lock | input | 1 | Lock request; sticky until reset |
| dram_addr | output | ADDR_W | Remapped DRAM address |
| hi_smram_hit | output | 1 | Address hits the enabled high window |
| tseg_hit | output | 1 | Address hits the enabled TSEG window |

## Verification
The bench builds the block with a 32-bit address, the register at offset 0x61 and TSEG_BASE set to 0x02000000. With these values the high window and the TSEG block sit far apart, so each hit can be checked in isolation.

Because the control byte is only 8 bits wide, all 256 write values can be swept before locking. For each of the eight combinations of global enable, high enable and TSEG enable, the bench probes addresses just inside and just outside both window edges and predicts every hit and remapped address arithmetically. It also covers the violation flag (SMM, invalid, set, ignored clear, real clear, and set against clear in the same cycle) and the lock, both while the input is held and after it drops.

// File: rtl/xsmm_pkg.sv
package xsmm_pkg;
    typedef enum logic {
        S_OPEN   = 1'b0,
        S_SEALED = 1'b1
    } seal_e;

    localparam int CFG_W          = 8;
    localparam logic [7:0] FORCED_ONES = 8'h38;
    localparam int WIN_SHIFT      = 20;
endpackage

// File: rtl/xsmm_seal_fsm.sv
module xsmm_seal_fsm
    import xsmm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lock_in,
    output logic wr_block
);
    seal_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_OPEN:   if (lock_in) state_d = S_SEALED;
            S_SEALED: state_d = S_SEALED;
            default:  state_d = S_OPEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        wr_block = lock_in;
        unique case (state_q)
            S_OPEN:   wr_block = lock_in;
            S_SEALED: wr_block = 1'b1;
            default:  wr_block = 1'b1;
        endcase
    end

    AST_SEAL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SEALED) |=> (state_q == S_SEALED)); // R7
endmodule

// File: rtl/xsmm_cfg_reg.sv
module xsmm_cfg_reg
    import xsmm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_hi,
    input  logic             wr_err,
    input  logic             wr_tseg,
    input  logic             wr_block,
    input  logic             viol_set,
    output logic [CFG_W-1:0] cfg_byte,
    output logic             hi_en,
    output logic             tseg_en
);
    logic hi_q, err_q, tseg_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q   <= 1'b0;
            err_q  <= 1'b0;
            tseg_q <= 1'b0;
        end else begin
            if (wr_en && !wr_block) begin
                hi_q   <= wr_hi;
                tseg_q <= wr_tseg;
            end
            if (viol_set)              err_q <= 1'b1;
            else if (wr_en && wr_err)  err_q <= 1'b0;
        end
    end

    always_comb begin
        cfg_byte    = FORCED_ONES;
        cfg_byte[7] = hi_q;
        cfg_byte[6] = err_q;
        cfg_byte[0] = tseg_q;
        hi_en       = hi_q;
        tseg_en     = tseg_q;
    end

    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_block |=> ($stable(hi_q) && $stable(tseg_q))); // R7
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        viol_set |=> err_q); // R5
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !(wr_en && wr_err)) |=> err_q); // R5
endmodule

// File: rtl/xsmm_win_decode.sv
module xsmm_win_decode
    import xsmm_pkg::*;
#(
    parameter int                ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] TSEG_BASE = ADDR_W'(32'h0800_0000)
) (
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              hi_on,
    input  logic              tseg_on,
    output logic              hi_hit,
    output logic              tseg_hit,
    output logic [ADDR_W-1:0] dram_addr
);
    localparam logic [ADDR_W-1:0] HI_LO    = ADDR_W'(32'hFEDA_0000);
    localparam logic [ADDR_W-1:0] HI_TOP   = ADDR_W'(32'hFEDB_FFFF);
    localparam logic [ADDR_W-1:0] HI_SHIFT = ADDR_W'(32'hFED0_0000);
    localparam int                TAG_W    = ADDR_W - WIN_SHIFT;

    logic in_hi, in_tseg;

    always_comb begin
        in_hi    = (cpu_addr >= HI_LO) && (cpu_addr <= HI_TOP);
        in_tseg  = cpu_addr[ADDR_W-1 -: TAG_W] == TSEG_BASE[ADDR_W-1 -: TAG_W];
        hi_hit   = hi_on && in_hi;
        tseg_hit = tseg_on && in_tseg;
        dram_addr = hi_hit ? (cpu_addr - HI_SHIFT) : cpu_addr;
    end
endmodule

// File: rtl/xsmm_ctrl.sv
module xsmm_ctrl
    import xsmm_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter int                REG_AW     = 8,
    parameter logic [REG_AW-1:0] REG_OFFSET = REG_AW'(8'h61),
    parameter logic [ADDR_W-1:0] TSEG_BASE  = ADDR_W'(32'h0800_0000)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              cpu_valid,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_in_smm,
    input  logic              smram_glb_en,
    input  logic              cfg_lock,
    output logic [ADDR_W-1:0] dram_addr,
    output logic              hi_smram_hit,
    output logic              tseg_hit
);
    logic             sel, wr_en, wr_block, viol_set;
    logic             hi_en, tseg_en;
    logic [CFG_W-1:0] cfg_byte;

    assign sel       = (reg_addr == REG_OFFSET);
    assign wr_en     = reg_we && sel;
    assign reg_rdata = sel ? cfg_byte : 8'h00;
    assign viol_set  = cpu_valid && !cpu_in_smm && (hi_smram_hit || tseg_hit);

    xsmm_seal_fsm u_seal (
        .clk      (clk),
        .rst_n    (rst_n),
        .lock_in  (cfg_lock),
        .wr_block (wr_block)
    );

    xsmm_cfg_reg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_hi    (reg_wdata[7]),
        .wr_err   (reg_wdata[6]),
        .wr_tseg  (reg_wdata[0]),
        .wr_block (wr_block),
        .viol_set (viol_set),
        .cfg_byte (cfg_byte),
        .hi_en    (hi_en),
        .tseg_en  (tseg_en)
    );

    xsmm_win_decode #(.ADDR_W(ADDR_W), .TSEG_BASE(TSEG_BASE)) u_dec (
        .cpu_addr  (cpu_addr),
        .hi_on     (smram_glb_en && hi_en),
        .tseg_on   (smram_glb_en && tseg_en),
        .hi_hit    (hi_smram_hit),
        .tseg_hit  (tseg_hit),
        .dram_addr (dram_addr)
    );

    AST_FIXED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        sel |-> (reg_rdata[5:3] == 3'b111 && reg_rdata[2:1] == 2'b00)); // R3
    AST_REMAP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        hi_smram_hit |-> (dram_addr >= ADDR_W'(32'h000A_0000) &&
                          dram_addr <= ADDR_W'(32'h000B_FFFF))); // R2
    AST_HIT_NEEDS_GLB: assert property (@(posedge clk) disable iff (!rst_n)
        !smram_glb_en |-> !(hi_smram_hit || tseg_hit)); // R6
    AST_NO_FLAG_IN_SMM: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_byte[6] && (cpu_in_smm || !cpu_valid)) |=> !cfg_byte[6]); // R9
endmodule

// File: tb/test_xsmm_ctrl.sv
module test_xsmm_ctrl;
    localparam logic [31:0] TB_BASE = 32'h0200_0000;
    localparam logic [7:0]  OFF     = 8'h61;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = OFF;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic        cpu_valid = 1'b0;
    logic [31:0] cpu_addr = 32'h0;
    logic        cpu_in_smm = 1'b0;
    logic        smram_glb_en = 1'b0;
    logic        cfg_lock = 1'b0;
    logic [31:0] dram_addr;
    logic        hi_smram_hit, tseg_hit;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    xsmm_ctrl #(.ADDR_W(32), .REG_AW(8), .REG_OFFSET(OFF), .TSEG_BASE(TB_BASE)) i_xsmm_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_valid(cpu_valid),
        .cpu_addr(cpu_addr), .cpu_in_smm(cpu_in_smm), .smram_glb_en(smram_glb_en),
        .cfg_lock(cfg_lock), .dram_addr(dram_addr), .hi_smram_hit(hi_smram_hit),
        .tseg_hit(tseg_hit)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_we = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = OFF;
        #1;
    endtask

    task automatic access(input logic [31:0] a, input logic smm, input logic v);
        @(negedge clk);
        cpu_addr = a; cpu_in_smm = smm; cpu_valid = v;
        @(negedge clk);
        cpu_valid = 1'b0; cpu_in_smm = 1'b0;
        #1;
    endtask

    function automatic logic [31:0] pick(input int i);
        case (i)
            0:  return 32'hFED9_FFFF;
            1:  return 32'hFEDA_0000;
            2:  return 32'hFEDA_0001;
            3:  return 32'hFEDB_FFFF;
            4:  return 32'hFEDC_0000;
            5:  return 32'hFEDA_1234;
            6:  return TB_BASE - 1;
            7:  return TB_BASE;
            8:  return TB_BASE + 32'h0008_0000;
            9:  return TB_BASE + 32'h000F_FFFF;
            10: return TB_BASE + 32'h0010_0000;
            default: return 32'h000A_0000;
        endcase
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 reset value", {24'h0, reg_rdata}, 32'h38);
        reg_addr = 8'h60; #1;
        chk("R1 other offset reads zero", {24'h0, reg_rdata}, 32'h0);
        reg_addr = OFF; #1;

        // R3/R4 exhaustive write sweep, flag clear so bit 6 reads 0
        for (int v = 0; v < 256; v++) begin
            logic [7:0] exp;
            wr(OFF, v[7:0]);
            exp = {v[7], 1'b0, 3'b111, 2'b00, v[0]};
            chk("R3/R4 write sweep", {24'h0, reg_rdata}, {24'h0, exp});
        end

        // R8 writes at another offset
        wr(OFF, 8'h00);
        wr(8'h62, 8'hFF);
        chk("R8 foreign offset write", {24'h0, reg_rdata}, 32'h38);

        // R2/R6/R8 decode sweep
        for (int c = 0; c < 8; c++) begin
            logic g, h, t;
            g = c[2]; h = c[1]; t = c[0];
            wr(OFF, {h, 6'b0, t});
            @(negedge clk);
            smram_glb_en = g;
            for (int i = 0; i < 12; i++) begin
                logic [31:0] a;
                logic eh, et;
                a = pick(i);
                cpu_addr = a;
                #1;
                eh = g && h && (a >= 32'hFEDA_0000) && (a <= 32'hFEDB_FFFF);
                et = g && t && (a >= TB_BASE) && (a < TB_BASE + 32'h0010_0000);
                chk("R2 high hit", {31'h0, hi_smram_hit}, {31'h0, eh});
                chk("R6 tseg hit", {31'h0, tseg_hit}, {31'h0, et});
                chk("R8/R2 dram addr", dram_addr, eh ? a - 32'hFED0_0000 : a);
            end
        end

        // R9 and R5 violation flag
        wr(OFF, 8'h81);
        smram_glb_en = 1'b1;
        access(32'hFEDA_0100, 1'b1, 1'b1);
        chk("R9 in-SMM access no flag", {24'h0, reg_rdata}, 32'hB9);
        access(TB_BASE, 1'b0, 1'b0);
        chk("R9 invalid access no flag", {24'h0, reg_rdata}, 32'hB9);
        access(32'h0000_1000, 1'b0, 1'b1);
        chk("R8 miss sets no flag", {24'h0, reg_rdata}, 32'hB9);
        access(TB_BASE + 32'h10, 1'b0, 1'b1);
        chk("R5 tseg violation sets flag", {24'h0, reg_rdata}, 32'hF9);
        wr(OFF, 8'h81);
        chk("R5 writing 0 keeps flag", {24'h0, reg_rdata}, 32'hF9);
        wr(OFF, 8'hC1);
        chk("R5 write 1 clears flag", {24'h0, reg_rdata}, 32'hB9);
        access(32'hFEDB_0000, 1'b0, 1'b1);
        chk("R5 high violation sets flag", {24'h0, reg_rdata}, 32'hF9);
        @(negedge clk);
        cpu_addr = 32'hFEDA_0000; cpu_valid = 1'b1; cpu_in_smm = 1'b0;
        reg_we = 1'b1; reg_wdata = 8'hC1;
        @(negedge clk);
        cpu_valid = 1'b0; reg_we = 1'b0; #1;
        chk("R5 set wins over clear", {24'h0, reg_rdata}, 32'hF9);
        wr(OFF, 8'hC1);
        chk("R5 clear after race", {24'h0, reg_rdata}, 32'hB9);

        // R7 lock
        @(negedge clk);
        cfg_lock = 1'b1; reg_we = 1'b1; reg_wdata = 8'h00;
        @(negedge clk);
        reg_we = 1'b0; #1;
        chk("R7 write in lock cycle ignored", {24'h0, reg_rdata}, 32'hB9);
        cfg_lock = 1'b0;
        wr(OFF, 8'h00);
        chk("R7 sticky lock", {24'h0, reg_rdata}, 32'hB9);
        access(TB_BASE, 1'b0, 1'b1);
        wr(OFF, 8'h40);
        chk("R7 flag clear while locked", {24'h0, reg_rdata}, 32'hB9);

        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1; #1;
        chk("R1 reset clears lock and bits", {24'h0, reg_rdata}, 32'h38);
        wr(OFF, 8'h01);
        chk("R7 unlocked after reset", {24'h0, reg_rdata}, 32'h39);

        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule